// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block is a sequencer that runs a counted loop body with no branch penalty on any pass. It holds the fetch address counter of a simple in-order front end. One setup command, given a few cycles before the body is reached, loads three values: the first body address, the last body address and the pass count. The body itself holds no loop-control instruction.

Each enabled cycle the sequencer compares the current fetch address with the stored last address, in parallel with the normal increment. On a match with more passes still to run, the next fetch address is the first body address. On the final pass, fetch carries on to the address after the body. The last body instruction is followed at once by the first one, so the fetch stream has no gap cycles. A run input acts as a clock enable for the whole front end, and a stall freezes all of its state.

Top module: `zol_seq`

## Requirements
- R1: After reset is released, `fetch_addr` equals `RESET_ADDR` (default 0), `loop_active` is 0 and `remaining` is 0.
- R2: While no loop is active and `run` is 1, `fetch_addr` rises by exactly 1 on every clock edge.
- R3: A cycle with `setup_vld` at 1 loads the loop. From the next cycle, `loop_active` is 1 and `remaining` equals `setup_count`. Fetch continues in sequence until it reaches `setup_start`.
- R4: A `setup_count` of 0 is treated as 1. The body runs once, and `remaining` shows 1 while the loop is active.
- R5: When `run` is 1, the loop is active, `fetch_addr` equals the stored last address and `remaining` is greater than 1, the next `fetch_addr` is the stored start address and `remaining` drops by 1. There is no gap cycle.
- R6: When `run` is 1, the loop is active, `fetch_addr` equals the stored last address and `remaining` is 1, the next `fetch_addr` is the last address plus 1. On that same edge, `loop_active` becomes 0 and `remaining` becomes 0. `remaining` is 0 whenever no loop is active.
- R7: While `run` is 0 and no setup is given, `fetch_addr`, `loop_active` and `remaining` keep their values.
- R8: The combinational output `next_addr` is the value that `fetch_addr` takes on the next clock edge with `run` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Fetch advance enable |
| setup_vld | input | 1 | Loop setup command strobe |
| setup_start | input | AW | Address of the first body instruction |
| setup_end | input | AW | Address of the last body instruction |
| setup_count | input | CW | Number of passes (0 means 1) |
| fetch_addr | output | AW | Current fetch address |
| next_addr | output | AW | Fetch address for the next enabled cycle |
| loop_active | output | 1 | A loop is in progress |
| remaining | output | CW | Passes left, counting the current one |

## Verification
Each registered result (`fetch_addr`, `loop_active`, `remaining`) appears one edge after the enabled cycle that caused it. A setup command given at one falling edge is therefore first visible after the next rising edge. The driver pushes one expected triple for every enabled edge, built from the start, end and count it was given. The monitor samples half a period after each rising edge and pops one entry only when `run` was high at that edge. On stalled edges it checks that nothing moved. `next_addr` is combinational, so the monitor compares it one edge later against the new `fetch_addr`.

// File: rtl/zol_pkg.sv
package zol_pkg;

  localparam int DEF_AW = 16;
  localparam int DEF_CW = 16;

  typedef enum logic {
    NXT_SEQ  = 1'b0,
    NXT_LOOP = 1'b1
  } nxt_sel_e;

endpackage

// File: rtl/zol_rst_sync.sv
module zol_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;

endmodule

// File: rtl/zol_pc.sv
module zol_pc #(
  parameter int            AW         = zol_pkg::DEF_AW,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic [AW-1:0] pc_nxt,
  output logic [AW-1:0] pc_q
);

  logic [AW-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    if (adv_en) pc_d = pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_ADDR;
    else        pc_q <= pc_d;
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(pc_q)); // R7

endmodule

// File: rtl/zol_next_sel.sv
module zol_next_sel #(
  parameter int AW = zol_pkg::DEF_AW,
  parameter int CW = zol_pkg::DEF_CW
) (
  input  logic               active,
  input  logic [AW-1:0]      pc,
  input  logic [AW-1:0]      body_first,
  input  logic [AW-1:0]      body_last,
  input  logic [CW-1:0]      passes_left,
  output zol_pkg::nxt_sel_e  sel,
  output logic               wrap_hit,
  output logic               exit_hit,
  output logic [AW-1:0]      nxt_addr
);
  import zol_pkg::*;

  localparam logic [CW-1:0] ONE = CW'(1);

  logic at_last;

  always_comb begin
    at_last  = active && (pc == body_last);
    wrap_hit = at_last && (passes_left > ONE);
    exit_hit = at_last && (passes_left <= ONE);
    sel      = wrap_hit ? NXT_LOOP : NXT_SEQ;
    case (sel)
      NXT_LOOP: nxt_addr = body_first;
      default:  nxt_addr = pc + AW'(1);
    endcase
  end

endmodule

// File: rtl/zol_loop_ctx.sv
module zol_loop_ctx #(
  parameter int AW = zol_pkg::DEF_AW,
  parameter int CW = zol_pkg::DEF_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic          ld_vld,
  input  logic [AW-1:0] ld_first,
  input  logic [AW-1:0] ld_last,
  input  logic [CW-1:0] ld_count,
  input  logic          wrap_hit,
  input  logic          exit_hit,
  output logic [AW-1:0] first_q,
  output logic [AW-1:0] last_q,
  output logic [CW-1:0] left_q,
  output logic          active_q
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          upd_en;
  logic [AW-1:0] first_d;
  logic [AW-1:0] last_d;
  logic [CW-1:0] left_d;
  logic          active_d;

  always_comb begin
    upd_en   = ld_vld || (adv_en && (wrap_hit || exit_hit));
    first_d  = first_q;
    last_d   = last_q;
    left_d   = left_q;
    active_d = active_q;
    if (ld_vld) begin
      first_d  = ld_first;
      last_d   = ld_last;
      left_d   = (ld_count == '0) ? ONE : ld_count;
      active_d = 1'b1;
    end else if (wrap_hit) begin
      left_d   = left_q - ONE;
    end else if (exit_hit) begin
      left_d   = '0;
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      last_q   <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
    end else if (upd_en) begin
      first_q  <= first_d;
      last_q   <= last_d;
      left_q   <= left_d;
      active_q <= active_d;
    end
  end

  AST_SETUP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |=> active_q && (left_q != '0)); // R3
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_count == '0) |=> (left_q == ONE)); // R4
  AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (left_q != '0)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (left_q == '0)); // R6
  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_en && !ld_vld) |=> $stable(left_q) && $stable(active_q)); // R7

endmodule

// File: rtl/zol_seq.sv
module zol_seq #(
  parameter int            AW         = zol_pkg::DEF_AW,
  parameter int            CW         = zol_pkg::DEF_CW,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          setup_vld,
  input  logic [AW-1:0] setup_start,
  input  logic [AW-1:0] setup_end,
  input  logic [CW-1:0] setup_count,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] next_addr,
  output logic          loop_active,
  output logic [CW-1:0] remaining
);
  import zol_pkg::*;

  logic          rst_sync_n;
  logic [AW-1:0] first_q;
  logic [AW-1:0] last_q;
  logic          wrap_hit;
  logic          exit_hit;
  nxt_sel_e      sel;

  zol_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  zol_pc #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_pc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv_en (run),
    .pc_nxt (next_addr),
    .pc_q   (fetch_addr)
  );

  zol_next_sel #(.AW(AW), .CW(CW)) u_sel (
    .active      (loop_active),
    .pc          (fetch_addr),
    .body_first  (first_q),
    .body_last   (last_q),
    .passes_left (remaining),
    .sel         (sel),
    .wrap_hit    (wrap_hit),
    .exit_hit    (exit_hit),
    .nxt_addr    (next_addr)
  );

  zol_loop_ctx #(.AW(AW), .CW(CW)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv_en   (run),
    .ld_vld   (setup_vld),
    .ld_first (setup_start),
    .ld_last  (setup_end),
    .ld_count (setup_count),
    .wrap_hit (wrap_hit),
    .exit_hit (exit_hit),
    .first_q  (first_q),
    .last_q   (last_q),
    .left_q   (remaining),
    .active_q (loop_active)
  );

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !loop_active) |=> fetch_addr == $past(fetch_addr) + AW'(1)); // R2
  AST_WRAP_BACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !setup_vld && sel == NXT_LOOP)
      |=> (fetch_addr == $past(first_q)) && (remaining == $past(remaining) - CW'(1))); // R5
  AST_EXIT_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !setup_vld && exit_hit)
      |=> !loop_active && (fetch_addr == $past(last_q) + AW'(1))); // R6
  AST_NEXT_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run |=> fetch_addr == $past(next_addr)); // R8

endmodule

// File: tb/zol_seq_bench.sv
module zol_seq_bench;

  localparam int AW = 16;
  localparam int CW = 16;

  typedef struct {
    int    addr;
    bit    act;
    int    rem;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          setup_vld = 1'b0;
  logic [AW-1:0] setup_start = '0;
  logic [AW-1:0] setup_end = '0;
  logic [CW-1:0] setup_count = '0;
  logic [AW-1:0] fetch_addr;
  logic [AW-1:0] next_addr;
  logic          loop_active;
  logic [CW-1:0] remaining;

  int   total = 0;
  int   bad = 0;
  bit   mon_en = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  zol_seq #(.AW(AW), .CW(CW)) u_zol_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .setup_vld   (setup_vld),
    .setup_start (setup_start),
    .setup_end   (setup_end),
    .setup_count (setup_count),
    .fetch_addr  (fetch_addr),
    .next_addr   (next_addr),
    .loop_active (loop_active),
    .remaining   (remaining)
  );

  task automatic push(int a, bit act, int rem, string req);
    exp_t e;
    e.addr = a; e.act = act; e.rem = rem; e.req = req;
    q.push_back(e);
  endtask

  task automatic free_run(int n);
    int p;
    wait (q.size() == 0);
    @(negedge clk);
    p = int'(fetch_addr);
    run = 1'b1;
    for (int i = 1; i <= n; i++) push(p + i, 1'b0, 0, "R2");
  endtask

  task automatic run_loop(int gap, int len, int cnt, int tail, int stall_at);
    int p, st, en, eff;
    string rq;
    wait (q.size() == 0);
    @(negedge clk);
    p   = int'(fetch_addr);
    st  = p + 1 + gap;
    en  = st + len - 1;
    eff = (cnt == 0) ? 1 : cnt;
    setup_start = AW'(st);
    setup_end   = AW'(en);
    setup_count = CW'(cnt);
    setup_vld   = 1'b1;
    run         = 1'b1;
    for (int a = p + 1; a < st; a++) push(a, 1'b1, eff, (cnt == 0) ? "R4" : "R3");
    for (int k = 1; k <= eff; k++) begin
      rq = (cnt == 0) ? "R4" : ((k == 1) ? "R3" : "R5");
      for (int a = st; a <= en; a++) push(a, 1'b1, eff - k + 1, rq);
    end
    for (int t = 1; t <= tail; t++) push(en + t, 1'b0, 0, (cnt == 0) ? "R4" : "R6");
    @(negedge clk);
    setup_vld = 1'b0;
    if (stall_at > 0) begin
      repeat (stall_at) @(negedge clk);
      run = 1'b0;
      repeat (3) @(negedge clk);
      run = 1'b1;
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic [AW-1:0] last_addr;
    logic [CW-1:0] last_rem;
    logic          last_act;
    logic [AW-1:0] nx;
    bit            nx_ok;
    bit            r;
    exp_t          e;
    nx_ok = 1'b0;
    last_addr = '0; last_rem = '0; last_act = 1'b0; nx = '0;
    forever begin
      @(posedge clk);
      r = run;
      #5;
      if (mon_en) begin
        if (r) begin
          if (nx_ok) begin
            total++;
            if (fetch_addr !== nx) begin
              bad++;
              $display("FAIL R8 next_addr: fetch_addr=%0d expected=%0d", fetch_addr, nx);
            end
          end
          if (q.size() > 0) begin
            e = q.pop_front();
            total++;
            if (fetch_addr !== AW'(e.addr) || loop_active !== e.act || remaining !== CW'(e.rem)) begin
              bad++;
              $display("FAIL %s: addr/act/rem=%0d/%0d/%0d expected=%0d/%0d/%0d",
                       e.req, fetch_addr, loop_active, remaining, e.addr, e.act, e.rem);
            end
          end
        end else begin
          total++;
          if (fetch_addr !== last_addr || remaining !== last_rem || loop_active !== last_act) begin
            bad++;
            $display("FAIL R7 stall: addr/act/rem=%0d/%0d/%0d expected=%0d/%0d/%0d",
                     fetch_addr, loop_active, remaining, last_addr, last_act, last_rem);
          end
        end
        last_addr = fetch_addr;
        last_rem  = remaining;
        last_act  = loop_active;
        nx        = next_addr;
        nx_ok     = 1'b1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (fetch_addr !== '0 || loop_active !== 1'b0 || remaining !== '0) begin
      bad++;
      $display("FAIL R1 reset: addr/act/rem=%0d/%0d/%0d expected=0/0/0",
               fetch_addr, loop_active, remaining);
    end
    mon_en = 1'b1;
    free_run(5);
    run_loop(2, 3, 4, 3, 0);
    run_loop(0, 1, 3, 2, 0);
    run_loop(1, 2, 1, 2, 0);
    run_loop(0, 3, 0, 2, 0);
    run_loop(1, 4, 3, 2, 6);
    run_loop(0, 2, 2, 2, 0);
    free_run(4);
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule